// File: doc/BRIEF.md
# Synchronous burst SRAM access controller

This block fronts a small pipelined static RAM that shares one data bus for reads and writes. On each rising clock edge it registers the address, the control strobes and the write data. It then decides whether the cycle starts a burst, continues or holds a burst, deselects the device, or does nothing. Three chip enables gate selection. Two address strobes start bursts under different priority rules: the processor strobe `adsp_n_i` and the controller strobe `adsc_n_i`. A global write input and a set of per-lane write enables become byte-lane write strobes. Each lane carries eight data bits and one parity bit.

The burst address itself is kept by a separate sequencer. The controller sends that sequencer a load command, which carries the start address, or an advance command. The controller then uses the sequencer's current address (`seq_addr_i`) for the array access in the following cycle. Read data passes through an output register. The output enable and the snooze input are not clocked: either one can take the bus driver off at once. The bus is modelled as separate read-data and drive-enable outputs, with no tri-state net.

Top module: `sbc_top`

## Requirements
- R1: The device is selected only when `ce_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0. A start cycle (see R3, R4) with any enable inactive is a deselect: no array access, no sequencer load, and `dq_oe_o` is 0 one clock after the deselect is registered.
- R2: While `ce_n_i`=1, `adsp_n_i` has no effect. In that state `adsc_n_i`=0 is a deselect that ends any burst. `adsc_n_i`=1 continues or holds an active burst, or does nothing when no burst is active.
- R3: `adsp_n_i`=0 with the device selected starts a read at `addr_i` whatever the write inputs are. It asserts `seq_load_o` with `seq_start_o`=`addr_i`.
- R4: `adsc_n_i`=0, with `adsp_n_i`=1 or `ce_n_i`=1 and the device selected, starts a burst at `addr_i` (`seq_load_o`=1). The cycle is a write if the write decode of R5 holds and a read otherwise.
- R5: The write decode holds when `gw_n_i`=0, or when `bwe_n_i`=0 and at least one bit of `bw_n_i` is 0. Otherwise the cycle is a read.
- R6: `gw_n_i`=0 writes every lane. With `gw_n_i`=1 and `bwe_n_i`=0, only lanes k with `bw_n_i[k]`=0 are written. Lane k is data bits [9k+7:9k] plus parity bit 9k+8.
- R7: A cycle with no start while a burst is active continues the burst. `adv_n_i`=0 asserts `seq_adv_o` and accesses the advanced address. `adv_n_i`=1 holds the burst and re-accesses the current address. Each continue cycle reads or writes as R5 decides. `seq_load_o` and `seq_adv_o` are never both 1.
- R8: For a read registered at edge E, `rdata_o` is loaded at edge E+1 and `dq_oe_o` is 1 from E+1 to E+2.
- R9: `oe_n_i`=1 or `zz_i`=1 forces `dq_oe_o` to 0 at once, without waiting for a clock edge.
- R10: While `zz_i`=1, clock edges ignore every other input: no write, no sequencer command, and the burst state is kept.
- R11: After reset no burst is active and `dq_oe_o`, `seq_load_o` and `seq_adv_o` are 0 when the bus inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External start address |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce3_n_i | input | 1 | Tertiary chip enable, active low |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | LANES | Per-lane write enables, active low |
| wdata_i | input | DW | Write data, 9 bits per lane |
| oe_n_i | input | 1 | Output enable, active low, not clocked |
| zz_i | input | 1 | Snooze, active high, not clocked |
| seq_addr_i | input | AW | Current burst address from the sequencer |
| seq_load_o | output | 1 | Sequencer load command |
| seq_adv_o | output | 1 | Sequencer advance command |
| seq_start_o | output | AW | Start address to load |
| rdata_o | output | DW | Read data output register |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The sequencer commands are combinational in the inputs of the cycle, so the bench checks them 1 ns after it drives its inputs on the falling edge. An array access takes place at the edge after the command is registered. Read data and `dq_oe_o` are therefore checked on the second falling edge after the stimulus. The release of the bus after a deselect is checked one falling edge later still. For the output enable and snooze, the bench changes the input in the middle of a cycle and samples 1 ns later, with no edge between the change and the sample.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_DESEL = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;
endpackage

// File: rtl/sbc_lanes.sv
module sbc_lanes #(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] bw_n_i,
  output logic             wr_req_o,
  output logic [LANES-1:0] lane_we_o
);
  always_comb begin
    if (!gw_n_i)       lane_we_o = '1;
    else if (!bwe_n_i) lane_we_o = ~bw_n_i;
    else               lane_we_o = '0;
  end

  assign wr_req_o = !gw_n_i || (!bwe_n_i && !(&bw_n_i));

  a_r6_global_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gw_n_i |-> (&lane_we_o));
  a_r5_no_enable_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_n_i && bwe_n_i) |-> (!wr_req_o && lane_we_o == '0));
endmodule

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic ce2_i,
  input  logic ce3_n_i,
  input  logic adsp_n_i,
  input  logic adsc_n_i,
  input  logic adv_n_i,
  input  logic wr_req_i,
  input  logic zz_i,
  input  logic burst_act_i,
  output cmd_e cmd_o,
  output logic seq_load_o,
  output logic seq_adv_o
);
  logic sel, adsp_go, start;

  assign sel     = !ce_n_i && ce2_i && !ce3_n_i;
  assign adsp_go = !adsp_n_i && !ce_n_i;   // processor strobe masked by primary enable
  assign start   = adsp_go || !adsc_n_i;

  always_comb begin
    cmd_o      = CMD_IDLE;
    seq_load_o = 1'b0;
    seq_adv_o  = 1'b0;
    if (!zz_i) begin
      if (start) begin
        if (!sel) cmd_o = CMD_DESEL;
        else begin
          seq_load_o = 1'b1;
          cmd_o      = (adsp_go || !wr_req_i) ? CMD_READ : CMD_WRITE;
        end
      end else if (burst_act_i) begin
        seq_adv_o = !adv_n_i;
        cmd_o     = wr_req_i ? CMD_WRITE : CMD_READ;
      end
    end
  end

  a_r3_adsp_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && !ce_n_i && !adsp_n_i) |-> (cmd_o != CMD_WRITE));
  a_r2_adsp_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && ce_n_i && adsc_n_i && !burst_act_i) |-> (cmd_o == CMD_IDLE && !seq_load_o));
  a_r1_unselected_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zz_i && !adsc_n_i && !(!ce_n_i && ce2_i && !ce3_n_i)) |-> (cmd_o == CMD_DESEL && !seq_load_o));
  a_r10_snooze_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |-> (!seq_load_o && !seq_adv_o && cmd_o == CMD_IDLE));
  a_r7_cmd_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seq_load_o && seq_adv_o));
endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
  parameter int DEPTH     = 64,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = LANE_BITS + 1,
  localparam int DW = LANES * LW
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [LANES-1:0] lane_we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && lane_we_i[l]) mem[addr_i] <= wdata_i[l*LW +: LW];
      if (re_i)                 rdata_o[l*LW +: LW] <= mem[addr_i];
    end
  end
endmodule

// File: rtl/sbc_top.sv
module sbc_top
  import sbc_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * (LANE_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             ce_n_i,
  input  logic             ce2_i,
  input  logic             ce3_n_i,
  input  logic             adsp_n_i,
  input  logic             adsc_n_i,
  input  logic             adv_n_i,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] bw_n_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             oe_n_i,
  input  logic             zz_i,
  input  logic [AW-1:0]    seq_addr_i,
  output logic             seq_load_o,
  output logic             seq_adv_o,
  output logic [AW-1:0]    seq_start_o,
  output logic [DW-1:0]    rdata_o,
  output logic             dq_oe_o
);
  cmd_e             cmd, cmd_q;
  logic             wr_req, act_q, rd_vld_q;
  logic [LANES-1:0] lane_we, lane_we_q;
  logic [DW-1:0]    wdata_q;

  sbc_lanes #(.LANES(LANES)) i_lanes (
    .clk_i, .rst_ni, .gw_n_i, .bwe_n_i, .bw_n_i,
    .wr_req_o (wr_req),
    .lane_we_o(lane_we)
  );

  sbc_decode i_decode (
    .clk_i, .rst_ni, .ce_n_i, .ce2_i, .ce3_n_i, .adsp_n_i, .adsc_n_i, .adv_n_i,
    .wr_req_i   (wr_req),
    .zz_i,
    .burst_act_i(act_q),
    .cmd_o      (cmd),
    .seq_load_o,
    .seq_adv_o
  );

  assign seq_start_o = addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= CMD_IDLE;
      act_q     <= 1'b0;
      lane_we_q <= '0;
      wdata_q   <= '0;
      rd_vld_q  <= 1'b0;
    end else begin
      cmd_q     <= cmd;
      lane_we_q <= lane_we;
      wdata_q   <= wdata_i;
      rd_vld_q  <= (cmd_q == CMD_READ);
      if (cmd == CMD_DESEL) act_q <= 1'b0;
      else if (seq_load_o)  act_q <= 1'b1;
    end
  end

  sbc_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_BITS(LANE_BITS)) i_array (
    .clk_i,
    .we_i     (cmd_q == CMD_WRITE),
    .re_i     (cmd_q == CMD_READ),
    .lane_we_i(lane_we_q),
    .addr_i   (seq_addr_i),
    .wdata_i  (wdata_q),
    .rdata_o
  );

  // bus drive is gated by the unclocked enables
  assign dq_oe_o = rd_vld_q && !oe_n_i && !zz_i;

  a_r1_desel_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_DESEL) |=> !dq_oe_o);
  a_r8_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> $past(cmd_q == CMD_READ));
  a_r9_async_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_n_i || zz_i) |-> !dq_oe_o);
  a_r10_snooze_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |=> $stable(act_q));
endmodule

// File: tb/test_sbc_top.sv
`timescale 1ns/1ps
module test_sbc_top;
  localparam int AW = 6;
  localparam int DW = 36;

  typedef struct packed {
    logic          op;     // 1: processor strobe start, 0: controller strobe start
    logic [AW-1:0] addr;
    logic          gw_n;
    logic          bwe_n;
    logic [3:0]    bw_n;
    logic [DW-1:0] wd;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 6'd4,  1'b0, 1'b1, 4'hF, 36'h9_1234_5678},
    '{1'b1, 6'd4,  1'b0, 1'b0, 4'h0, 36'hF_FFFF_FFFF},
    '{1'b0, 6'd4,  1'b1, 1'b0, 4'hE, 36'hA_AAAA_AAAA},
    '{1'b0, 6'd4,  1'b1, 1'b1, 4'h0, 36'h0_0000_0000},
    '{1'b0, 6'd4,  1'b1, 1'b0, 4'hF, 36'h3_3333_3333},
    '{1'b0, 6'd8,  1'b0, 1'b1, 4'hF, 36'h1_0101_0101},
    '{1'b0, 6'd9,  1'b0, 1'b1, 4'hF, 36'h2_0202_0202},
    '{1'b0, 6'd10, 1'b0, 1'b1, 4'hF, 36'h3_0303_0303},
    '{1'b0, 6'd11, 1'b1, 1'b0, 4'h0, 36'h4_0404_0404},
    '{1'b0, 6'd4,  1'b1, 1'b0, 4'h5, 36'h5_5555_5555},
    '{1'b1, 6'd4,  1'b1, 1'b1, 4'hF, 36'h0_0000_0000},
    '{1'b0, 6'd11, 1'b1, 1'b1, 4'hF, 36'h0_0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr, seq_a, seq_start;
  logic ce_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, zz;
  logic [3:0] bw_n;
  logic [DW-1:0] wdata, rdata;
  logic seq_load, seq_adv, dq_oe;
  logic [DW-1:0] mdl [64];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sbc_top i_sbc_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_n_i(ce_n), .ce2_i(ce2), .ce3_n_i(ce3_n),
    .adsp_n_i(adsp_n), .adsc_n_i(adsc_n), .adv_n_i(adv_n), .gw_n_i(gw_n), .bwe_n_i(bwe_n),
    .bw_n_i(bw_n), .wdata_i(wdata), .oe_n_i(oe_n), .zz_i(zz), .seq_addr_i(seq_a),
    .seq_load_o(seq_load), .seq_adv_o(seq_adv), .seq_start_o(seq_start),
    .rdata_o(rdata), .dq_oe_o(dq_oe)
  );

  // neighbouring linear burst sequencer
  always @(posedge clk or negedge rst_n)
    if (!rst_n) seq_a <= '0;
    else if (seq_load) seq_a <= seq_start;
    else if (seq_adv) seq_a[1:0] <= seq_a[1:0] + 2'd1;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic cen, c2, c3n, spn, scn, avn, g, be,
                     input logic [3:0] b, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = cen; ce2 = c2; ce3_n = c3n; adsp_n = spn; adsc_n = scn; adv_n = avn;
    gw_n = g; bwe_n = be; bw_n = b; addr = a; wdata = d;
  endtask

  task automatic desel();
    drv(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, '0, '0);
  endtask
  task automatic start_c(input logic [AW-1:0] a, input logic g, be, input logic [3:0] b,
                         input logic [DW-1:0] d);
    drv(0, 1, 0, 1, 0, 1, g, be, b, a, d);
  endtask
  task automatic cont(input logic avn, g, input logic [DW-1:0] d);
    drv(0, 1, 0, 1, 1, avn, g, 1, 4'hF, '0, d);
  endtask
  task automatic mdl_wr(input logic [AW-1:0] a, input logic g, be, input logic [3:0] b,
                        input logic [DW-1:0] d);
    for (int l = 0; l < 4; l++)
      if (!g || (!be && !b[l])) mdl[a][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    oe_n = 0; zz = 0;
    desel();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 oe after reset", dq_oe, 0);
    chk("R11 load after reset", seq_load, 0);
    chk("R11 adv after reset", seq_adv, 0);

    // table: one start, one deselect, then check read result
    for (int i = 0; i < 12; i++) begin
      vec_t v;
      logic is_rd;
      v = VECS[i];
      is_rd = v.op || (v.gw_n && (v.bwe_n || (&v.bw_n)));
      if (v.op) drv(0, 1, 0, 0, 1, 1, v.gw_n, v.bwe_n, v.bw_n, v.addr, v.wd);
      else      start_c(v.addr, v.gw_n, v.bwe_n, v.bw_n, v.wd);
      #1 chk("R3 R4 start load", seq_load, 1);
      chk("R3 R4 start addr", seq_start, v.addr);
      if (!is_rd) mdl_wr(v.addr, v.gw_n, v.bwe_n, v.bw_n, v.wd);
      @(negedge clk); desel();
      @(negedge clk);
      chk("R8 R5 bus drive", dq_oe, is_rd);
      if (is_rd) chk("R5 R6 read data", rdata, mdl[v.addr]);
    end

    // R1: unselected start writes nothing
    drv(0, 0, 0, 1, 0, 1, 0, 1, 4'hF, 6'd4, 36'hF_0F0F_0F0F);
    #1 chk("R1 ce2 low no load", seq_load, 0);
    @(negedge clk); drv(0, 1, 1, 0, 1, 1, 1, 1, 4'hF, 6'd4, '0);
    #1 chk("R1 ce3 high no load", seq_load, 0);
    @(negedge clk); desel();
    @(negedge clk); chk("R1 no drive after deselect", dq_oe, 0);
    start_c(6'd4, 1, 1, 4'hF, '0);
    @(negedge clk); desel();
    @(negedge clk); chk("R1 memory untouched", rdata, mdl[4]);
    chk("R1 read drives", dq_oe, 1);
    @(negedge clk); chk("R1 release one cycle after deselect", dq_oe, 0);

    // R2: processor strobe masked with no burst active
    drv(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd8, '0);
    #1 chk("R2 masked adsp no load", seq_load, 0);
    chk("R2 masked adsp no adv", seq_adv, 0);
    @(negedge clk); desel();
    @(negedge clk); chk("R2 masked adsp no access", dq_oe, 0);
    // R2: masked adsp during burst continues it
    start_c(6'd8, 1, 1, 4'hF, '0);
    @(negedge clk); drv(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'd0, '0);
    #1 chk("R2 continue advances", seq_adv, 1);
    @(negedge clk); chk("R2 burst first", rdata, mdl[8]);
    drv(1, 1, 0, 0, 0, 1, 1, 1, 4'hF, 6'd0, '0);   // ADSC low while ce_n high: deselect
    #1 chk("R2 adsc deselect no load", seq_load, 0);
    @(negedge clk); chk("R2 continued read", rdata, mdl[9]);
    chk("R2 continued read drives", dq_oe, 1);
    desel();
    @(negedge clk); chk("R2 deselect ends burst", dq_oe, 0);

    // R7: burst read with advance, wrap and hold
    start_c(6'd10, 1, 1, 4'hF, '0);
    @(negedge clk); cont(0, 1, '0);
    #1 chk("R7 advance command", seq_adv, 1);
    @(negedge clk); chk("R7 beat0", rdata, mdl[10]); cont(0, 1, '0);
    @(negedge clk); chk("R7 beat1", rdata, mdl[11]); cont(1, 1, '0);
    #1 chk("R7 hold no advance", seq_adv, 0);
    chk("R7 hold no load", seq_load, 0);
    @(negedge clk); chk("R7 wrapped beat", rdata, mdl[8]); desel();
    @(negedge clk); chk("R7 held beat", rdata, mdl[8]);

    // R3: processor start ignores write inputs; write on a later edge
    drv(0, 1, 0, 0, 1, 1, 0, 0, 4'h0, 6'd8, 36'hE_EEEE_EEEE);
    @(negedge clk); cont(0, 0, 36'h7_7777_7777);
    mdl_wr(6'd9, 0, 1, 4'hF, 36'h7_7777_7777);
    @(negedge clk); chk("R3 start read data", rdata, mdl[8]); desel();
    @(negedge clk); start_c(6'd8, 1, 1, 4'hF, '0);
    @(negedge clk); cont(0, 1, '0);
    @(negedge clk); chk("R3 start did not write", rdata, mdl[8]); desel();
    @(negedge clk); chk("R7 continue write landed", rdata, mdl[9]);

    // R9: unclocked enables
    start_c(6'd8, 1, 1, 4'hF, '0); oe_n = 1;
    @(negedge clk); desel();
    @(negedge clk); chk("R9 oe high no drive", dq_oe, 0);
    chk("R9 output register loaded", rdata, mdl[8]);
    oe_n = 0;
    #1 chk("R9 oe low drives at once", dq_oe, 1);
    zz = 1;
    #1 chk("R9 snooze stops drive at once", dq_oe, 0);
    zz = 0;

    // R10: snooze ignores a write start
    @(negedge clk); zz = 1; start_c(6'd4, 0, 1, 4'hF, 36'hC_CCCC_CCCC);
    #1 chk("R10 no load in snooze", seq_load, 0);
    @(negedge clk); desel();
    @(negedge clk); zz = 0; start_c(6'd4, 1, 1, 4'hF, '0);
    @(negedge clk); desel();
    @(negedge clk); chk("R10 write ignored", rdata, mdl[4]);

    finish_run();
  end
endmodule